// File: doc/BRIEF.md
# External Oscillator Loss Guard with Clock Failover

This block watches the external crystal oscillator clock and uses the always-running internal RC oscillator clock as its timebase. The raw crystal signal is brought into the RC clock domain through a short synchronizer, and a window counter measures how long it has been since the last rising edge. The crystal is sensed directly, not the PLL output, because a PLL that has lost its reference keeps free-running at a low frequency and would still look alive.

When the window runs out while monitoring is armed, the block does several things in one clock edge. It forces the system clock mux select to the internal oscillator and turns the internal oscillator enable on. It clears the external oscillator enable. It clears the PLL enable, but only when the PLL takes its reference from the crystal. It also sets a sticky non-maskable interrupt request and drives a brake line toward an advanced timer. Software controls the block through single-cycle strobe inputs: arm, disarm, set and clear the enables, select a clock source, and clear the flag.

Top module: `clk_guard`

## Requirements
- R1: After reset the block is disarmed. The select and status read 2'b00 (internal oscillator), the RC enable is 1, and the crystal enable, PLL enable, interrupt request and brake are all 0.
- R2: While disarmed, a stopped crystal clock never raises the interrupt request.
- R3: While armed, with the crystal ready and enabled and a rising edge at least once every WIN_CYC RC cycles, no fault is declared and the block stays armed.
- R4: While armed, with the crystal ready and enabled, if no synchronized rising edge is seen for WIN_CYC RC cycles, then in the same cycle that the interrupt request rises the select becomes 2'b00, the RC enable is 1, the crystal enable is 0 and the block disarms. No fault is declared within WIN_CYC-8 cycles of the crystal stopping.
- R5: On a fault the PLL enable is cleared when `pll_src_xo` is 1, and keeps its value when `pll_src_xo` is 0.
- R6: The brake output is asserted exactly while the interrupt request is set.
- R7: The interrupt request stays set until a `flag_clr` strobe. That strobe clears both the request and the brake.
- R8: A `sel_req` strobe loads `sel_code` into the select: 2'b00 internal, 2'b01 crystal, 2'b10 PLL. The code 2'b11 is ignored. The status output equals the select one cycle later.
- R9: After a failover, software can turn the crystal and PLL enables back on. The select stays 2'b00 until a `sel_req` strobe. Monitoring stays off until a new arm strobe, so stopping the crystal again raises nothing.
- R10: Monitoring is held off while `xtal_rdy` is low, even when armed.
- R11: An `rc_off` strobe clears the RC enable only while the select is not 2'b00. While the internal oscillator is selected, the strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rc_clk | input | 1 | Internal RC oscillator clock, timebase of the block |
| rst_n | input | 1 | Active-low reset, synchronous to rc_clk |
| xtal_clk | input | 1 | Raw external crystal oscillator clock |
| xtal_rdy | input | 1 | Crystal oscillator reports stable |
| arm_set | input | 1 | Strobe: arm monitoring |
| arm_clr | input | 1 | Strobe: disarm monitoring |
| flag_clr | input | 1 | Strobe: clear interrupt request and brake |
| xo_on | input | 1 | Strobe: set crystal enable |
| xo_off | input | 1 | Strobe: clear crystal enable |
| pll_on | input | 1 | Strobe: set PLL enable |
| pll_off | input | 1 | Strobe: clear PLL enable |
| pll_src_xo | input | 1 | PLL reference is the crystal (1) or the RC oscillator (0) |
| rc_off | input | 1 | Strobe: clear RC enable |
| sel_req | input | 1 | Strobe: load sel_code into the clock select |
| sel_code | input | 2 | Requested system clock source |
| clk_sel | output | 2 | System clock mux select |
| clk_sts | output | 2 | Source currently driving the system clock |
| rc_en | output | 1 | Internal RC oscillator enable |
| xo_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | PLL enable |
| guard_armed | output | 1 | Monitoring is armed |
| nmi_req | output | 1 | Sticky non-maskable interrupt request |
| brake | output | 1 | Brake request to the advanced timer |

## Verification
The assertions assume that every software input is a single-cycle strobe synchronous to rc_clk and that `pll_src_xo` only changes while no fault is about to be declared. The bench drives every strobe for exactly one RC cycle, just after a rising edge, and changes `pll_src_xo` only while the crystal is running. The crystal clock is generated at 50 MHz, slow enough that the synchronizer sees every edge. Fault windows are checked against bounds that allow for the crystal phase at the moment it stops and for the synchronizer latency, rather than against a single exact cycle.

// File: rtl/clk_guard_pkg.sv
package clk_guard_pkg;
   typedef enum logic [1:0] {
      SRC_RC  = 2'b00,
      SRC_XO  = 2'b01,
      SRC_PLL = 2'b10,
      SRC_RSV = 2'b11
   } clk_src_e;

   typedef struct packed {
      logic arm_set;
      logic arm_clr;
      logic flag_clr;
      logic xo_on;
      logic xo_off;
      logic pll_on;
      logic pll_off;
      logic rc_off;
      logic sel_req;
   } sw_cmd_t;
endpackage

// File: rtl/clk_guard_sync.sv
module clk_guard_sync #(
   parameter int STAGES      = 2,
   parameter bit DETECT_BOTH = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic edge_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("clk_guard_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] shreg;
   logic              last_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg  <= '0;
         last_q <= 1'b0;
      end else begin
         shreg  <= {shreg[STAGES-2:0], async_in};
         last_q <= shreg[STAGES-1];
      end
   end

   if (DETECT_BOTH) begin : g_both
      assign edge_o = shreg[STAGES-1] ^ last_q;
   end else begin : g_rise
      assign edge_o = shreg[STAGES-1] & ~last_q;
   end
endmodule

// File: rtl/clk_guard_watch.sv
module clk_guard_watch #(
   parameter int WIN_CYC = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic edge_seen,
   output logic fault
);
   if (WIN_CYC < 4) begin : g_bad_win
      $error("clk_guard_watch: WIN_CYC must be at least 4");
   end

   localparam int CW = $clog2(WIN_CYC);
   localparam logic [CW-1:0] LIMIT = CW'(WIN_CYC - 1);

   logic [CW-1:0] gap_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap_q <= '0;
      end else if (!active || edge_seen) begin
         gap_q <= '0;
      end else if (gap_q != LIMIT) begin
         gap_q <= gap_q + 1'b1;
      end
   end

   assign fault = active & ~edge_seen & (gap_q == LIMIT);
endmodule

// File: rtl/clk_guard_ctrl.sv
module clk_guard_ctrl
   import clk_guard_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  sw_cmd_t    cmd,
   input  logic [1:0] sel_code,
   input  logic       pll_src_xo,
   input  logic       fault,
   output logic [1:0] sel,
   output logic [1:0] sts,
   output logic       rc_en,
   output logic       xo_en,
   output logic       pll_en,
   output logic       armed,
   output logic       nmi
);
   clk_src_e sel_q, sts_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q  <= SRC_RC;
         sts_q  <= SRC_RC;
         rc_en  <= 1'b1;
         xo_en  <= 1'b0;
         pll_en <= 1'b0;
         armed  <= 1'b0;
         nmi    <= 1'b0;
      end else begin
         sts_q <= sel_q;
         if (fault) begin
            sel_q <= SRC_RC;
            rc_en <= 1'b1;
            xo_en <= 1'b0;
            armed <= 1'b0;
            nmi   <= 1'b1;
            if (pll_src_xo) begin
               pll_en <= 1'b0;
            end else if (cmd.pll_on) begin
               pll_en <= 1'b1;
            end else if (cmd.pll_off) begin
               pll_en <= 1'b0;
            end
         end else begin
            if (cmd.sel_req && clk_src_e'(sel_code) != SRC_RSV) begin
               sel_q <= clk_src_e'(sel_code);
            end
            if (cmd.rc_off && sel_q != SRC_RC) begin
               rc_en <= 1'b0;
            end
            if (cmd.xo_on) begin
               xo_en <= 1'b1;
            end else if (cmd.xo_off) begin
               xo_en <= 1'b0;
            end
            if (cmd.pll_on) begin
               pll_en <= 1'b1;
            end else if (cmd.pll_off) begin
               pll_en <= 1'b0;
            end
            if (cmd.arm_set) begin
               armed <= 1'b1;
            end else if (cmd.arm_clr) begin
               armed <= 1'b0;
            end
            if (cmd.flag_clr) begin
               nmi <= 1'b0;
            end
         end
      end
   end

   assign sel = sel_q;
   assign sts = sts_q;
endmodule

// File: rtl/clk_guard.sv
module clk_guard
   import clk_guard_pkg::*;
#(
   parameter int WIN_CYC     = 64,
   parameter int SYNC_STAGES = 2,
   parameter bit DETECT_BOTH = 1'b0
) (
   input  logic       rc_clk,
   input  logic       rst_n,
   input  logic       xtal_clk,
   input  logic       xtal_rdy,
   input  logic       arm_set,
   input  logic       arm_clr,
   input  logic       flag_clr,
   input  logic       xo_on,
   input  logic       xo_off,
   input  logic       pll_on,
   input  logic       pll_off,
   input  logic       pll_src_xo,
   input  logic       rc_off,
   input  logic       sel_req,
   input  logic [1:0] sel_code,
   output logic [1:0] clk_sel,
   output logic [1:0] clk_sts,
   output logic       rc_en,
   output logic       xo_en,
   output logic       pll_en,
   output logic       guard_armed,
   output logic       nmi_req,
   output logic       brake
);
   sw_cmd_t cmd;
   logic    xtal_edge;
   logic    watch_on;
   logic    det_fault;

   assign cmd = '{arm_set: arm_set, arm_clr: arm_clr, flag_clr: flag_clr,
                  xo_on: xo_on, xo_off: xo_off, pll_on: pll_on,
                  pll_off: pll_off, rc_off: rc_off, sel_req: sel_req};

   clk_guard_sync #(.STAGES(SYNC_STAGES), .DETECT_BOTH(DETECT_BOTH)) u_sync (
      .clk      (rc_clk),
      .rst_n    (rst_n),
      .async_in (xtal_clk),
      .edge_o   (xtal_edge)
   );

   assign watch_on = guard_armed & xtal_rdy & xo_en;

   clk_guard_watch #(.WIN_CYC(WIN_CYC)) u_watch (
      .clk       (rc_clk),
      .rst_n     (rst_n),
      .active    (watch_on),
      .edge_seen (xtal_edge),
      .fault     (det_fault)
   );

   clk_guard_ctrl u_ctrl (
      .clk        (rc_clk),
      .rst_n      (rst_n),
      .cmd        (cmd),
      .sel_code   (sel_code),
      .pll_src_xo (pll_src_xo),
      .fault      (det_fault),
      .sel        (clk_sel),
      .sts        (clk_sts),
      .rc_en      (rc_en),
      .xo_en      (xo_en),
      .pll_en     (pll_en),
      .armed      (guard_armed),
      .nmi        (nmi_req)
   );

   assign brake = nmi_req;
endmodule

// File: rtl/clk_guard_chk.sv
module clk_guard_chk (
   input logic       rc_clk,
   input logic       rst_n,
   input logic       pll_src_xo,
   input logic       pll_off,
   input logic       rc_off,
   input logic       flag_clr,
   input logic       sel_req,
   input logic       det_fault,
   input logic [1:0] clk_sel,
   input logic [1:0] clk_sts,
   input logic       rc_en,
   input logic       xo_en,
   input logic       pll_en,
   input logic       guard_armed,
   input logic       nmi_req,
   input logic       brake
);
   p_reroute_r4: assert property (@(posedge rc_clk) disable iff (!rst_n)
      $rose(nmi_req) |-> (clk_sel == 2'b00 && rc_en && !xo_en && !guard_armed));

   p_only_armed_r2: assert property (@(posedge rc_clk) disable iff (!rst_n)
      $rose(nmi_req) |-> $past(guard_armed));

   p_pll_cut_r5: assert property (@(posedge rc_clk) disable iff (!rst_n)
      ($rose(nmi_req) && $past(pll_src_xo)) |-> !pll_en);

   p_pll_keep_r5: assert property (@(posedge rc_clk) disable iff (!rst_n)
      ($rose(nmi_req) && !$past(pll_src_xo) && $past(pll_en) && !$past(pll_off)) |-> pll_en);

   p_brake_r6: assert property (@(posedge rc_clk) disable iff (!rst_n)
      brake == nmi_req);

   p_sticky_r7: assert property (@(posedge rc_clk) disable iff (!rst_n)
      (nmi_req && !flag_clr) |=> nmi_req);

   p_sts_lag_r8: assert property (@(posedge rc_clk) disable iff (!rst_n)
      1'b1 |=> clk_sts == $past(clk_sel));

   p_sel_hold_r9: assert property (@(posedge rc_clk) disable iff (!rst_n)
      (!sel_req && !det_fault) |=> $stable(clk_sel));

   p_rc_keep_r11: assert property (@(posedge rc_clk) disable iff (!rst_n)
      (clk_sel == 2'b00 && rc_en) |=> rc_en);
endmodule

bind clk_guard clk_guard_chk u_chk (
   .rc_clk      (rc_clk),
   .rst_n       (rst_n),
   .pll_src_xo  (pll_src_xo),
   .pll_off     (pll_off),
   .rc_off      (rc_off),
   .flag_clr    (flag_clr),
   .sel_req     (sel_req),
   .det_fault   (det_fault),
   .clk_sel     (clk_sel),
   .clk_sts     (clk_sts),
   .rc_en       (rc_en),
   .xo_en       (xo_en),
   .pll_en      (pll_en),
   .guard_armed (guard_armed),
   .nmi_req     (nmi_req),
   .brake       (brake)
);

// File: tb/tb_clk_guard.sv
`timescale 1ns/1ps
module tb_clk_guard;
   localparam int WIN = 64;

   logic       rc_clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       xtal_clk = 1'b0;
   logic       xtal_run = 1'b0;
   logic       xtal_rdy = 1'b0;
   logic       arm_set = 0, arm_clr = 0, flag_clr = 0, xo_on = 0, xo_off = 0;
   logic       pll_on = 0, pll_off = 0, pll_src_xo = 0, rc_off = 0, sel_req = 0;
   logic [1:0] sel_code = 2'b00;
   logic [1:0] clk_sel, clk_sts;
   logic       rc_en, xo_en, pll_en, guard_armed, nmi_req, brake;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 0;

   always #2 rc_clk = ~rc_clk;
   always #10 xtal_clk = xtal_run ? ~xtal_clk : 1'b0;

   clk_guard #(.WIN_CYC(WIN)) dut (
      .rc_clk(rc_clk), .rst_n(rst_n), .xtal_clk(xtal_clk), .xtal_rdy(xtal_rdy),
      .arm_set(arm_set), .arm_clr(arm_clr), .flag_clr(flag_clr),
      .xo_on(xo_on), .xo_off(xo_off), .pll_on(pll_on), .pll_off(pll_off),
      .pll_src_xo(pll_src_xo), .rc_off(rc_off), .sel_req(sel_req),
      .sel_code(sel_code), .clk_sel(clk_sel), .clk_sts(clk_sts),
      .rc_en(rc_en), .xo_en(xo_en), .pll_en(pll_en),
      .guard_armed(guard_armed), .nmi_req(nmi_req), .brake(brake)
   );

   // observed vector: {sel[9:8], sts[7:6], rc_en, xo_en, pll_en, armed, nmi, brake}
   localparam logic [9:0] M_ALL = 10'h3FF;
   localparam logic [9:0] M_SEL = 10'h300;
   localparam logic [9:0] M_STS = 10'h0C0;
   localparam logic [9:0] M_RC  = 10'h020;
   localparam logic [9:0] M_XO  = 10'h010;
   localparam logic [9:0] M_PLL = 10'h008;
   localparam logic [9:0] M_ARM = 10'h004;
   localparam logic [9:0] M_IRQ = 10'h003;

   typedef struct {
      string      tag;
      logic [9:0] mask;
      logic [9:0] exp;
   } item_t;
   item_t sb_q[$];

   function automatic logic [9:0] mk(logic [1:0] s, logic [1:0] t, logic r, logic x,
                                     logic p, logic a, logic n, logic b);
      return {s, t, r, x, p, a, n, b};
   endfunction

   task automatic tick(input int n);
      repeat (n) @(posedge rc_clk);
      #1;
   endtask

   task automatic expect_obs(input string tag, input logic [9:0] mask, input logic [9:0] exp);
      item_t it;
      it.tag = tag; it.mask = mask; it.exp = exp;
      sb_q.push_back(it);
   endtask

   // strobe codes: 0 arm_set 1 arm_clr 2 flag_clr 3 xo_on 4 xo_off 5 pll_on 6 pll_off 7 rc_off 8 sel_req
   task automatic strobe(input int which, input logic [1:0] code);
      case (which)
         0: arm_set = 1;  1: arm_clr = 1;  2: flag_clr = 1;
         3: xo_on = 1;    4: xo_off = 1;   5: pll_on = 1;
         6: pll_off = 1;  7: rc_off = 1;
         default: begin sel_req = 1; sel_code = code; end
      endcase
      tick(1);
      {arm_set, arm_clr, flag_clr, xo_on, xo_off, pll_on, pll_off, rc_off, sel_req} = '0;
   endtask

   always @(negedge rc_clk) begin
      while (sb_q.size() > 0) begin
         item_t it;
         logic [9:0] obs;
         it = sb_q.pop_front();
         obs = {clk_sel, clk_sts, rc_en, xo_en, pll_en, guard_armed, nmi_req, brake};
         n_run++;
         if ((obs & it.mask) !== (it.exp & it.mask)) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b (mask %b)", it.tag,
                     obs & it.mask, it.exp & it.mask, it.mask);
         end
      end
   end

   initial begin
      #(4 * 150000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      tick(5);
      rst_n = 1'b1;
      tick(1);
      expect_obs("R1 reset state", M_ALL, mk(2'b00, 2'b00, 1, 0, 0, 0, 0, 0));
      tick(1);

      strobe(7, 2'b00);
      expect_obs("R11 rc_off ignored on internal", M_RC, 10'h020);

      xtal_run = 1; xtal_rdy = 1;
      strobe(3, 2'b00);
      expect_obs("R8 xo_en set", M_XO, 10'h010);
      strobe(8, 2'b01);
      expect_obs("R8 select crystal", M_SEL, 10'h100);
      tick(1);
      expect_obs("R8 status crystal", M_STS, 10'h040);
      strobe(8, 2'b11);
      tick(1);
      expect_obs("R8 reserved code ignored", M_SEL | M_STS, 10'h140);
      strobe(7, 2'b00);
      expect_obs("R11 rc_off honoured off internal", M_RC, 10'h000);

      xtal_run = 0;
      tick(200);
      expect_obs("R2 no fault when disarmed", M_IRQ | M_ARM, 10'h000);
      xtal_run = 1;
      tick(10);

      xtal_rdy = 0;
      strobe(0, 2'b00);
      xtal_run = 0;
      tick(200);
      expect_obs("R10 held off without ready", M_IRQ | M_ARM, 10'h004);
      xtal_run = 1;
      tick(10);
      xtal_rdy = 1;
      tick(300);
      expect_obs("R3 running crystal no fault", M_IRQ | M_ARM | M_SEL, 10'h104);

      pll_src_xo = 1;
      strobe(5, 2'b00);
      strobe(8, 2'b10);
      tick(1);
      expect_obs("R8 status PLL", M_STS | M_PLL, 10'h088);
      xtal_run = 0;
      tick(WIN - 8);
      expect_obs("R4 no early fault", M_IRQ | M_ARM, 10'h004);
      tick(18);
      expect_obs("R4 failover", M_SEL | M_RC | M_XO | M_ARM | M_IRQ, mk(2'b00, 2'b00, 1, 0, 0, 0, 1, 1));
      expect_obs("R5 PLL cut when fed by crystal", M_PLL, 10'h000);
      expect_obs("R6 brake follows flag", M_IRQ, 10'h003);
      tick(1);
      expect_obs("R8 status internal after failover", M_STS, 10'h000);

      tick(20);
      expect_obs("R7 flag sticky", M_IRQ, 10'h003);
      strobe(2, 2'b00);
      expect_obs("R7 flag and brake cleared", M_IRQ, 10'h000);

      xtal_run = 1;
      strobe(3, 2'b00);
      strobe(5, 2'b00);
      tick(50);
      expect_obs("R9 re-enable keeps internal select", M_SEL | M_STS | M_XO | M_PLL, 10'h018);
      xtal_run = 0;
      tick(200);
      expect_obs("R9 no fault before re-arm", M_IRQ | M_ARM, 10'h000);
      xtal_run = 1;
      tick(10);
      strobe(8, 2'b01);
      expect_obs("R9 explicit reselect", M_SEL, 10'h100);

      pll_src_xo = 0;
      strobe(0, 2'b00);
      tick(30);
      xtal_run = 0;
      tick(WIN + 10);
      expect_obs("R5 PLL kept when fed by RC", M_PLL | M_XO | M_IRQ, 10'h00B);
      expect_obs("R4 second failover select", M_SEL | M_ARM, 10'h000);
      tick(2);

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule